// File: doc/BRIEF.md
# Display Refresh Address Pipeline

This block produces the video-memory read address used to refresh a flat-panel display. A scan counter steps once per pixel clock while the timing generator holds its count-enable high. It returns to zero on a frame-start pulse. The counter value passes through one register stage before it reaches the memory. The memory read data then goes on the same clock to the data output that feeds the display transmitter. The display-enable and the two sync strobes from the timing generator are delayed by one pixel clock inside the block, so they stay in step with the data, which arrives one cycle late.

A processor access is not arbitrated against the refresh. While a processor request is asserted, its address, write strobe and write data take over the memory port in the next cycle. The processor never waits. The price is a few wrong pixels on screen: during an override write the transmitter shows the bus data, and during an override read it shows whatever the memory returns for the processor address. The scan counter keeps running through the override, so the raster does not lose its place.

Top module: `scan_refresh_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `mem_addr` is zero and `mem_we`, `tx_de`, `tx_hsync` and `tx_vsync` are low.
- R2: A clock edge with `frame_start` high sets the scan counter to zero, even when `count_en` is also high.
- R3: A clock edge with `count_en` high and `frame_start` low adds one to the scan counter.
- R4: A clock edge with both `count_en` and `frame_start` low leaves the scan counter unchanged.
- R5: When `cpu_req` is low at a clock edge, `mem_addr` after that edge equals the scan counter value from before the edge, and `mem_we` is low.
- R6: When `cpu_req` is high at a clock edge, `mem_addr`, `mem_we` and `mem_wdata` after that edge equal `cpu_addr`, `cpu_we` and `cpu_wdata` as they were at the edge.
- R7: The scan counter follows R2 to R4 whether or not `cpu_req` is high.
- R8: `tx_data` equals `mem_wdata` while `mem_we` is high and equals `mem_rdata` otherwise, with no register in between.
- R9: `tx_de`, `tx_hsync` and `tx_vsync` equal `de_in`, `hsync_in` and `vsync_in` from one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse that zeroes the scan counter |
| count_en | input | 1 | Scan counter step enable, low in blanking |
| de_in | input | 1 | Display-enable from the timing generator |
| hsync_in | input | 1 | Horizontal sync from the timing generator |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| cpu_req | input | 1 | Processor access request, overrides the scan address |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | 20 | Processor memory address |
| cpu_wdata | input | 16 | Processor write data |
| mem_addr | output | 20 | Registered memory address |
| mem_we | output | 1 | Registered memory write strobe |
| mem_wdata | output | 16 | Registered memory write data |
| mem_rdata | input | 16 | Memory read data |
| tx_data | output | 16 | Pixel data to the transmitter |
| tx_de | output | 1 | Display-enable aligned with `tx_data` |
| tx_hsync | output | 1 | Horizontal sync aligned with `tx_data` |
| tx_vsync | output | 1 | Vertical sync aligned with `tx_data` |

## Verification
The bench fires frame-start pulses together with count-enable, so a design that lets the step win would show address one instead of zero after a frame start. It holds count-enable low for runs of cycles, and it drives processor bursts of reads and writes over a running scan. A design that stalled the counter during an override would show a scan address that lags behind after the burst ends. A design that dropped the address register, or left the sync strobes undelayed, would show data, sync and enable one pixel apart. That shows up on every cycle of the comparison against the bench's own memory pattern.

// File: rtl/scan_pkg.sv
package scan_pkg;

    parameter int unsigned ADDR_W = 20;
    parameter int unsigned DATA_W = 16;

    typedef logic [ADDR_W-1:0] vaddr_t;
    typedef logic [DATA_W-1:0] pix_t;

    typedef struct packed {
        logic vs;
        logic hs;
        logic de;
    } sync_t;

    typedef struct packed {
        logic   we;
        vaddr_t addr;
        pix_t   wdata;
    } mem_req_t;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_STEP  = 2'd1,
        CNT_CLEAR = 2'd2
    } cnt_op_e;

    function automatic cnt_op_e decode_op(input logic fs, input logic ce);
        if (fs)
            return CNT_CLEAR;
        else if (ce)
            return CNT_STEP;
        else
            return CNT_HOLD;
    endfunction

    function automatic vaddr_t next_addr(input cnt_op_e op, input vaddr_t cur);
        case (op)
            CNT_CLEAR: return '0;
            CNT_STEP:  return cur + vaddr_t'(1);
            default:   return cur;
        endcase
    endfunction

endpackage

// File: rtl/scan_counter.sv
module scan_counter
    import scan_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_start,
    input  logic   count_en,
    output vaddr_t scan_addr
);

    cnt_op_e op;
    vaddr_t  cnt_q;

    always_comb op = decode_op(frame_start, count_en);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= next_addr(op, cnt_q);
    end

    assign scan_addr = cnt_q;

    AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (cnt_q == '0)); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && count_en) |=> (cnt_q == $past(cnt_q) + vaddr_t'(1))); // R3

    AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !count_en) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/scan_addr_stage.sv
module scan_addr_stage
    import scan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  vaddr_t   scan_addr,
    input  logic     cpu_req,
    input  mem_req_t cpu_side,
    output mem_req_t mem_side
);

    mem_req_t sel;
    mem_req_t q;

    always_comb begin
        if (cpu_req) begin
            sel = cpu_side;
        end else begin
            sel.we    = 1'b0;
            sel.addr  = scan_addr;
            sel.wdata = cpu_side.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= sel;
    end

    assign mem_side = q;

    AST_SCAN_ADDR_LATE: assert property (@(posedge clk) disable iff (rst)
        !cpu_req |=> (q.addr == $past(scan_addr)) && !q.we); // R5

    AST_CPU_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        cpu_req |=> (q.addr == $past(cpu_side.addr)) && (q.we == $past(cpu_side.we))); // R6

endmodule

// File: rtl/scan_sync_delay.sv
module scan_sync_delay
    import scan_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  sync_t sync_in,
    output sync_t sync_out
);

    sync_t q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= sync_in;
    end

    assign sync_out = q;

    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q == $past(sync_in))); // R9

endmodule

// File: rtl/scan_refresh_top.sv
module scan_refresh_top
    import scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              count_en,
    input  logic              de_in,
    input  logic              hsync_in,
    input  logic              vsync_in,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_de,
    output logic              tx_hsync,
    output logic              tx_vsync
);

    vaddr_t   scan_addr;
    mem_req_t cpu_side;
    mem_req_t mem_side;
    sync_t    sync_in;
    sync_t    sync_out;

    always_comb begin
        cpu_side.we    = cpu_we;
        cpu_side.addr  = cpu_addr;
        cpu_side.wdata = cpu_wdata;
        sync_in.de     = de_in;
        sync_in.hs     = hsync_in;
        sync_in.vs     = vsync_in;
    end

    scan_counter u_cnt (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .count_en    (count_en),
        .scan_addr   (scan_addr)
    );

    scan_addr_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .scan_addr (scan_addr),
        .cpu_req   (cpu_req),
        .cpu_side  (cpu_side),
        .mem_side  (mem_side)
    );

    scan_sync_delay u_sync (
        .clk      (clk),
        .rst      (rst),
        .sync_in  (sync_in),
        .sync_out (sync_out)
    );

    assign mem_addr  = mem_side.addr;
    assign mem_we    = mem_side.we;
    assign mem_wdata = mem_side.wdata;

    // Pixel path: memory data straight through, bus data wins on an override write
    always_comb tx_data = mem_side.we ? mem_side.wdata : mem_rdata;

    assign tx_de    = sync_out.de;
    assign tx_hsync = sync_out.hs;
    assign tx_vsync = sync_out.vs;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (mem_addr == '0) && !mem_we && !tx_de && !tx_hsync && !tx_vsync); // R1

    AST_WRITE_DATA_LATE: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we) |=> mem_we && (tx_data == $past(cpu_wdata))); // R8

endmodule

// File: tb/tb_scan_refresh_top.sv
`timescale 1ns/1ps
module tb_scan_refresh_top;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int NCYC = 4000;

    logic          clk = 1'b0;
    logic          rst;
    logic          frame_start, count_en, de_in, hsync_in, vsync_in;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wdata, mem_rdata, tx_data;
    logic          tx_de, tx_hsync, tx_vsync;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[15:0] ^ {a[19:16], 12'h5C3};
    endfunction

    assign mem_rdata = pat(mem_addr);

    scan_refresh_top dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .count_en(count_en),
        .de_in(de_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_de(tx_de), .tx_hsync(tx_hsync), .tx_vsync(tx_vsync)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // watchdog
    initial begin
        #(200000 * 20);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int unsigned   ref_cnt;
        string         cnt_tag;
        logic [AW-1:0] e_addr;
        logic          e_we, e_de, e_hs, e_vs;
        logic [DW-1:0] e_wd;
        string         a_tag;
        logic [31:0]   lfsr;
        int            hold_left;
        int            burst_left;

        lfsr = 32'hACE1_2468;
        ref_cnt = 0;
        cnt_tag = "R1";
        hold_left = 0;
        burst_left = 0;
        rst = 1'b1; frame_start = 1'b0; count_en = 1'b0;
        de_in = 1'b0; hsync_in = 1'b0; vsync_in = 1'b0;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(negedge clk);
            // reference model: apply the inputs seen at the last rising edge
            if (rst) begin
                e_addr = '0; e_we = 1'b0; e_wd = '0;
                e_de = 1'b0; e_hs = 1'b0; e_vs = 1'b0;
                ref_cnt = 0; cnt_tag = "R1"; a_tag = "R1";
            end else begin
                if (cpu_req) begin
                    e_addr = cpu_addr; e_we = cpu_we; e_wd = cpu_wdata; a_tag = "R6";
                end else begin
                    e_addr = ref_cnt[AW-1:0]; e_we = 1'b0; e_wd = cpu_wdata;
                    a_tag = {"R5 ", cnt_tag};
                end
                e_de = de_in; e_hs = hsync_in; e_vs = vsync_in;
                if (frame_start) begin
                    ref_cnt = 0; cnt_tag = "R2";
                end else if (count_en) begin
                    ref_cnt = (ref_cnt + 1) % (1 << AW); cnt_tag = "R3";
                end else begin
                    cnt_tag = "R4";
                end
                if (cpu_req) cnt_tag = {cnt_tag, " R7"};
            end

            check(a_tag, "mem_addr", mem_addr, e_addr);
            check(rst ? "R1" : "R5 R6", "mem_we", mem_we, e_we);
            if (e_we) check("R6", "mem_wdata", mem_wdata, e_wd);
            check("R8", "tx_data", tx_data, e_we ? e_wd : pat(e_addr));
            check("R9", "tx_de", tx_de, e_de);
            check("R9", "tx_hsync", tx_hsync, e_hs);
            check("R9", "tx_vsync", tx_vsync, e_vs);

            // next stimulus
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rst = (cyc < 4) || (cyc >= 2000 && cyc < 2003);
            frame_start = (cyc % 613 == 40) || (cyc == 1500) || (lfsr[9:0] == 10'h3FF);
            if (hold_left > 0) begin
                hold_left--;
                count_en = 1'b0;
            end else if (lfsr[7:4] == 4'hF) begin
                hold_left = 5 + int'(lfsr[2:0]);
                count_en = 1'b0;
            end else begin
                count_en = 1'b1;
            end
            if (cyc == 1500) count_en = 1'b1; // R2 clear beats step
            de_in = count_en;
            hsync_in = lfsr[12] & lfsr[13];
            vsync_in = lfsr[14] & lfsr[15] & lfsr[16];
            if (burst_left > 0) begin
                burst_left--;
                cpu_req = 1'b1;
            end else if (lfsr[23:19] == 5'h11) begin
                burst_left = 1 + int'(lfsr[26:25]);
                cpu_req = 1'b1;
            end else begin
                cpu_req = 1'b0;
            end
            cpu_we = lfsr[28];
            cpu_addr = {lfsr[31:20], lfsr[7:0]};
            cpu_wdata = lfsr[27:12];
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule